// File: doc/BRIEF.md
# Video Memory Access Slot Scheduler

This block decides, for every memory cycle of a scanline, which client owns a shared 8-bit video DRAM. The pixel clock drives it, and one memory cycle lasts two pixel clocks. A start strobe marks the first pixel clock of each cycle. A 3-bit code names the owner of the current cycle.

During the active part of a line, each group of four cycles fetches background name, pattern and colour bytes, and leaves one spare cycle. The spare cycles go to sprite evaluation, except for one in every four, which goes to the host CPU. In horizontal blanking, a run of sprite attribute and pattern fetches comes first, and CPU cycles fill the rest of the line. In vertical blanking, or while rendering is switched off, every cycle belongs to the CPU.

A CPU access request is remembered until the next CPU cycle begins. A busy flag shows that a request is waiting. The line position restarts on each rising edge of horizontal sync.

Top module: `vram_slot_sched`

## Requirements
- R1: While rst_ni is low and just after it is released, the pixel position is 0. The outputs then show slot code 0 (name fetch), cyc_start_o high, cpu_busy_o low, and both grants low.
- R2: A memory cycle lasts two pixel clocks. cyc_start_o is high on even pixel positions 0,2,4,... and low on odd ones.
- R3: For memory cycle m = pixel/2 with m < 128, the slot code is m mod 4 whenever m mod 4 is 0, 1 or 2. The codes are 0 for name, 1 for pattern and 2 for colour.
- R4: An active spare cycle (m mod 4 = 3) gets code 5 (CPU) when m mod 16 = 15, and code 3 (sprite evaluation) otherwise. This gives 24 evaluation cycles and 8 CPU cycles per active line.
- R5: In blanking, cycles 128 to 151 get code 4 (sprite fetch). Cycles 152 to 170 get code 5 (CPU).
- R6: While vblank_i is high, every cycle gets code 5 and spr_gnt_o stays low.
- R7: While render_off_i is high, every cycle gets code 5 and spr_gnt_o stays low.
- R8: A rising edge of hsync_i puts the pixel position at 0 on the next clock. Holding hsync_i high does not restart it again.
- R9: Without sync, the pixel position counts 0 to 341 and then wraps to 0.
- R10: A cpu_req_i pulse that comes when no CPU cycle is starting sets cpu_busy_o from the next clock. cpu_gnt_o is then asserted for one clock at the start of the next CPU cycle, and cpu_busy_o falls after that clock.
- R11: A cpu_req_i that is high while a CPU cycle starts is granted in that same clock, and cpu_busy_o stays low.
- R12: spr_gnt_o is high exactly on the start clock of code 3 and code 4 cycles. It is never high together with cpu_gnt_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync; the line restarts on its rising edge |
| vblank_i | input | 1 | Vertical blanking; all cycles go to the CPU |
| render_off_i | input | 1 | Rendering disabled; all cycles go to the CPU |
| cpu_req_i | input | 1 | CPU access request |
| slot_o | output | 3 | Owner code of the current memory cycle |
| cyc_start_o | output | 1 | First pixel clock of a memory cycle |
| cpu_gnt_o | output | 1 | CPU access granted in this cycle |
| spr_gnt_o | output | 1 | Sprite evaluation or fetch access in this cycle |
| cpu_busy_o | output | 1 | A CPU request is waiting for its slot |

## Verification
The hardest case to reach is a request that must wait. It has to arrive at a known line position where no CPU cycle is starting, including the second pixel clock of a CPU cycle. It must then be served exactly at the next CPU cycle start, thirteen or more cycles later. The bench makes this case by pulsing hsync_i to fix the line position, then counting clocks to the chosen pixel before it pulses cpu_req_i. It checks grant and busy on every clock up to the expected grant. A second hsync_i that is held high, issued in the middle of a line, checks that only the edge restarts the count.

// File: rtl/vram_sched_pkg.sv
`timescale 1ns/1ps
package vram_sched_pkg;
  typedef enum logic [2:0] {
    SLOT_NAME   = 3'd0,
    SLOT_PATT   = 3'd1,
    SLOT_COLR   = 3'd2,
    SLOT_SEVAL  = 3'd3,
    SLOT_SFETCH = 3'd4,
    SLOT_CPU    = 3'd5
  } slot_e;
endpackage

// File: rtl/vsched_line_ctr.sv
`timescale 1ns/1ps
module vsched_line_ctr #(
  parameter int LINE_PIX = 342,
  localparam int PXW = $clog2(LINE_PIX)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           hsync_i,
  output logic [PXW-1:0] px_o,
  output logic           cyc_start_o
);
  localparam logic [PXW-1:0] PX_LAST = PXW'(LINE_PIX - 1);

  logic hs_q;
  logic hs_rise;

  assign hs_rise = hsync_i & ~hs_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hs_q <= 1'b0;
      px_o <= '0;
    end else begin
      hs_q <= hsync_i;
      if (hs_rise || px_o == PX_LAST) px_o <= '0;
      else                            px_o <= px_o + 1'b1;
    end
  end

  // even pixels open a memory cycle
  assign cyc_start_o = ~px_o[0];

  AST_PX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    px_o <= PX_LAST); // R9
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (px_o == PX_LAST && !hs_rise) |=> px_o == '0); // R9
  AST_HS_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hs_rise |=> px_o == '0); // R8
  AST_CYC_ALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_start_o && !hs_rise) |=> !cyc_start_o); // R2
endmodule

// File: rtl/vsched_slot_dec.sv
`timescale 1ns/1ps
module vsched_slot_dec
  import vram_sched_pkg::*;
#(
  parameter int MCW         = 8,
  parameter int ACT_CYC     = 128,
  parameter int SFETCH_CYC  = 24,
  parameter int SPARE_RATIO = 4
) (
  input  logic [MCW-1:0] mc_i,
  input  logic           vblank_i,
  input  logic           render_off_i,
  output slot_e          slot_o
);
  localparam int GRP  = 4;
  localparam int SPAN = GRP * SPARE_RATIO;
  localparam logic [MCW-1:0] ACT_W   = MCW'(ACT_CYC);
  localparam logic [MCW-1:0] SF_END  = MCW'(ACT_CYC + SFETCH_CYC);
  localparam logic [MCW-1:0] SPAN_M  = MCW'(SPAN - 1);

  always_comb begin
    slot_o = SLOT_CPU;
    if (!vblank_i && !render_off_i) begin
      if (mc_i < ACT_W) begin
        unique case (mc_i[1:0])
          2'd0: slot_o = SLOT_NAME;
          2'd1: slot_o = SLOT_PATT;
          2'd2: slot_o = SLOT_COLR;
          default: slot_o = ((mc_i & SPAN_M) == SPAN_M) ? SLOT_CPU : SLOT_SEVAL;
        endcase
      end else if (mc_i < SF_END) begin
        slot_o = SLOT_SFETCH;
      end
    end
  end
endmodule

// File: rtl/vsched_cpu_arb.sv
`timescale 1ns/1ps
module vsched_cpu_arb
  import vram_sched_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cyc_start_i,
  input  slot_e slot_i,
  input  logic  cpu_req_i,
  output logic  cpu_gnt_o,
  output logic  cpu_busy_o
);
  logic pend_q;

  assign cpu_gnt_o  = cyc_start_i && (slot_i == SLOT_CPU) && (pend_q || cpu_req_i);
  assign cpu_busy_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (pend_q | cpu_req_i) & ~cpu_gnt_o;
  end

  AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && !cpu_gnt_o) |=> pend_q); // R10
  AST_GNT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_gnt_o |=> !cpu_busy_o); // R11
  AST_BUSY_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_busy_o) |-> $past(cpu_req_i)); // R10
endmodule

// File: rtl/vram_slot_sched.sv
`timescale 1ns/1ps
module vram_slot_sched
  import vram_sched_pkg::*;
#(
  parameter int LINE_PIX    = 342,
  parameter int ACT_PIX     = 256,
  parameter int SFETCH_CYC  = 24,
  parameter int SPARE_RATIO = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       hsync_i,
  input  logic       vblank_i,
  input  logic       render_off_i,
  input  logic       cpu_req_i,
  output logic [2:0] slot_o,
  output logic       cyc_start_o,
  output logic       cpu_gnt_o,
  output logic       spr_gnt_o,
  output logic       cpu_busy_o
);
  localparam int PXW     = $clog2(LINE_PIX);
  localparam int MCW     = PXW - 1;
  localparam int ACT_CYC = ACT_PIX / 2;

  logic [PXW-1:0] px;
  slot_e          slot;

  vsched_line_ctr #(.LINE_PIX(LINE_PIX)) u_line (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hsync_i    (hsync_i),
    .px_o       (px),
    .cyc_start_o(cyc_start_o)
  );

  vsched_slot_dec #(
    .MCW        (MCW),
    .ACT_CYC    (ACT_CYC),
    .SFETCH_CYC (SFETCH_CYC),
    .SPARE_RATIO(SPARE_RATIO)
  ) u_dec (
    .mc_i        (px[PXW-1:1]),
    .vblank_i    (vblank_i),
    .render_off_i(render_off_i),
    .slot_o      (slot)
  );

  vsched_cpu_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cyc_start_i(cyc_start_o),
    .slot_i     (slot),
    .cpu_req_i  (cpu_req_i),
    .cpu_gnt_o  (cpu_gnt_o),
    .cpu_busy_o (cpu_busy_o)
  );

  assign slot_o    = slot;
  assign spr_gnt_o = cyc_start_o && (slot == SLOT_SEVAL || slot == SLOT_SFETCH);

  AST_GNT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_gnt_o, spr_gnt_o})); // R12
  AST_VB_NO_SPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vblank_i |-> !spr_gnt_o); // R6
  AST_OFF_NO_SPR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    render_off_i |-> !spr_gnt_o); // R7
  AST_GNT_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_gnt_o || spr_gnt_o) |-> cyc_start_o); // R12
endmodule

// File: tb/vram_slot_sched_tb_top.sv
`timescale 1ns/1ps
module vram_slot_sched_tb_top;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic hsync_i = 1'b0, vblank_i = 1'b0, render_off_i = 1'b0, cpu_req_i = 1'b0;
  logic [2:0] slot_o;
  logic cyc_start_o, cpu_gnt_o, spr_gnt_o, cpu_busy_o;
  int vectors = 0;
  int fails = 0;

  always #5 clk_i = ~clk_i;

  vram_slot_sched dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .hsync_i(hsync_i), .vblank_i(vblank_i),
    .render_off_i(render_off_i), .cpu_req_i(cpu_req_i), .slot_o(slot_o),
    .cyc_start_o(cyc_start_o), .cpu_gnt_o(cpu_gnt_o), .spr_gnt_o(spr_gnt_o),
    .cpu_busy_o(cpu_busy_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_slot(int p, bit vb, bit off);
    int m = p / 2;
    if (vb || off) return 5;
    if (m < 128) begin
      if (m % 4 != 3) return m % 4;
      return (m % 16 == 15) ? 5 : 3;
    end
    return (m < 152) ? 4 : 5;
  endfunction

  task automatic step();
    @(posedge clk_i); #1;
  endtask

  // hsync pulse: pixel position is 0 once this returns
  task automatic do_sync();
    hsync_i = 1'b1; step(); hsync_i = 1'b0; #1;
  endtask

  task automatic t_reset();
    #1;
    chk("R1", "slot in reset", slot_o, 0);
    chk("R1", "busy in reset", cpu_busy_o, 0);
    step(); step();
    rst_ni = 1'b1; #1;
    chk("R1", "slot after reset", slot_o, 0);
    chk("R1", "cyc_start after reset", cyc_start_o, 1);
    chk("R1", "busy after reset", cpu_busy_o, 0);
    chk("R1", "grants after reset", {cpu_gnt_o, spr_gnt_o}, 0);
  endtask

  task automatic t_line_sweep(bit vb, bit off);
    int n_eval = 0, n_fetch = 0, n_cpu = 0;
    string rq = vb ? "R6" : (off ? "R7" : "R3/R4/R5");
    vblank_i = vb; render_off_i = off;
    do_sync();
    for (int p = 0; p < 342; p++) begin
      int es = exp_slot(p, vb, off);
      bit ev = (p % 2 == 0);
      chk(rq, $sformatf("slot px%0d", p), slot_o, es);
      chk("R2", $sformatf("cyc_start px%0d", p), cyc_start_o, ev);
      chk("R12", $sformatf("spr_gnt px%0d", p), spr_gnt_o, ev && (es == 3 || es == 4));
      if (cyc_start_o && slot_o == 3) n_eval++;
      if (cyc_start_o && slot_o == 4) n_fetch++;
      if (cyc_start_o && slot_o == 5) n_cpu++;
      step();
    end
    chk("R9", "wrap to pixel 0 slot", slot_o, exp_slot(0, vb, off));
    chk("R9", "wrap cyc_start", cyc_start_o, 1);
    if (!vb && !off) begin
      chk("R4", "eval cycles per line", n_eval, 24);
      chk("R5", "fetch cycles per line", n_fetch, 24);
      chk("R4", "cpu cycles per line", n_cpu, 27);
    end else begin
      chk(rq, "cpu cycles per line", n_cpu, 171);
    end
    vblank_i = 1'b0; render_off_i = 1'b0;
  endtask

  // request at pixel rp waits for the CPU cycle starting at gp
  task automatic t_wait_req(int rp, int gp);
    do_sync();
    for (int p = 0; p < rp; p++) step();
    cpu_req_i = 1'b1; #1;
    chk("R10", "no grant at request", cpu_gnt_o, 0);
    step(); cpu_req_i = 1'b0; #1;
    for (int p = rp + 1; p < gp; p++) begin
      chk("R10", $sformatf("busy while waiting px%0d", p), cpu_busy_o, 1);
      chk("R10", $sformatf("no early grant px%0d", p), cpu_gnt_o, 0);
      step();
    end
    chk("R10", "grant at cpu slot", cpu_gnt_o, 1);
    chk("R10", "slot at grant", slot_o, 5);
    step();
    chk("R10", "busy cleared", cpu_busy_o, 0);
    chk("R10", "grant one clock", cpu_gnt_o, 0);
  endtask

  task automatic t_direct_req();
    do_sync();
    for (int p = 0; p < 30; p++) step();
    cpu_req_i = 1'b1; #1;
    chk("R11", "immediate grant", cpu_gnt_o, 1);
    chk("R11", "no busy before", cpu_busy_o, 0);
    step(); cpu_req_i = 1'b0; #1;
    chk("R11", "no busy after", cpu_busy_o, 0);
    chk("R11", "no second grant", cpu_gnt_o, 0);
  endtask

  task automatic t_vblank_req();
    vblank_i = 1'b1;
    do_sync();
    for (int p = 0; p < 5; p++) step();
    cpu_req_i = 1'b1; #1;
    chk("R6", "no grant on odd pixel", cpu_gnt_o, 0);
    step(); cpu_req_i = 1'b0; #1;
    chk("R6", "grant at next pixel", cpu_gnt_o, 1);
    step();
    chk("R6", "busy cleared", cpu_busy_o, 0);
    vblank_i = 1'b0;
  endtask

  task automatic t_hsync_level();
    do_sync();
    for (int p = 0; p < 100; p++) step();
    hsync_i = 1'b1;
    for (int p = 0; p < 11; p++) step();
    // rise restarted at 0, then 10 more clocks with hsync held high
    chk("R8", "held sync slot px10", slot_o, exp_slot(10, 0, 0));
    for (int p = 0; p < 5; p++) step();
    chk("R8", "held sync slot px15", slot_o, exp_slot(15, 0, 0));
    chk("R8", "held sync cyc_start px15", cyc_start_o, 0);
    hsync_i = 1'b0;
    for (int p = 0; p < 8; p++) step();
    chk("R8", "slot px23", slot_o, exp_slot(23, 0, 0));
    do_sync();
    chk("R8", "mid-line restart slot", slot_o, 0);
    chk("R8", "mid-line restart cyc_start", cyc_start_o, 1);
  endtask

  initial begin
    t_reset();
    t_line_sweep(0, 0);
    t_line_sweep(1, 0);
    t_line_sweep(0, 1);
    t_wait_req(2, 30);
    t_wait_req(31, 62);
    t_direct_req();
    t_vblank_req();
    t_hsync_level();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule